// File: doc/BRIEF.md
# TDM Channel Port with Control Register

This block is the serial side of a low-speed data codec that lives in one 8-bit channel of a 2.048 Mbit/s time-division bus. Once per 125 us frame, two active-low enables open a channel window of eight bit periods. During that window the port shifts out the word supplied by the encoder, most significant bit first. In the same bit periods it shifts in a word from the remote end and a control word. The data and control words arrive on separate serial inputs.

After all eight bits are in, the received data word moves to a parallel holding register for the decoder, and the control word is loaded into the control register. The control register is split into a mode number, three bits of payload for the line-side violation word, and two flag-clear levels. One mode returns the previously received word on the outgoing channel. Another mode raises a general-purpose drive point. The line-side coding and decoding are handled by neighbouring blocks.

The serial output is intended for an external three-state pad. The port supplies the data bit and a separate drive enable.

Top module: `tdm_chan_port`

## Requirements
- R1: The window opens only on a rising clock edge where `frame_n` and `chan_n` are both sampled low. If only one of them is low, for any number of cycles, `tx_oe` stays 0 and neither holding register changes.
- R2: `tx_oe` goes high from the first rising edge at which both enables are sampled low. It stays high for at most W cycles, and `tx_ser` presents the outgoing word MSB first, starting with bit W-1 in that first cycle. Whenever `tx_oe` is 0, `tx_ser` is 0.
- R3: `rx_ser` and `ctl_ser` are sampled on falling edges while `tx_oe` is high, MSB first. On the falling edge that takes the W-th bit, both complete words are copied at once to `rx_word` and to the control register, and `rx_new` pulses for one cycle. A partial word is never copied.
- R4: The control register and `rx_word` are loaded at most once per window. Bits offered after the W-th bit of a window held open longer than W cycles are ignored. A new window needs at least one edge with an enable sampled high.
- R5: Control word fields: `mode` = bits 7:5, `vw_bits` = bits 4:2, `clr_activity` = bit 1 and `clr_scan` = bit 0. All of them hold their value until the next load.
- R6: When the mode at window start is 3 (loopback), the outgoing word is the `rx_word` received in the previous window. In every other mode, the outgoing word is `enc_word`.
- R7: `drive_pt` is 1 exactly while the mode is 6, and it returns to 0 when another mode is loaded.
- R8: While `rst` is high, `tx_oe` is 0, the control register holds 8'hFF (mode 7, idle, both clear levels 1) and `rx_word` is 0.
- R9: A window with `ctl_ser` held low loads 0 into the control register, which selects mode 0 with all fields cleared.
- R10: The outgoing word is captured at the first bit of the window. A change of `enc_word` during the window does not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, nominally 2.048 MHz |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame enable |
| chan_n | input | 1 | Active-low channel-address enable |
| rx_ser | input | 1 | Serial data word from the remote end |
| ctl_ser | input | 1 | Serial control word |
| enc_word | input | W | Parallel word from the encoder |
| tx_ser | output | 1 | Serial outgoing bit, MSB first |
| tx_oe | output | 1 | Drive enable for the external three-state pad |
| rx_word | output | W | Last complete received word |
| rx_new | output | 1 | One-cycle pulse when `rx_word` is loaded |
| mode | output | 3 | Operating mode from the control register |
| vw_bits | output | 3 | Violation-word payload bits |
| clr_activity | output | 1 | Clear level for the data-activity flag |
| clr_scan | output | 1 | Clear level for the scan-point flag |
| drive_pt | output | 1 | Drive-point output, high in mode 6 |

## Verification
The bench holds a window open for twelve cycles, with all-ones junk on both serial inputs after the eighth bit. A port that counted past W would keep driving, or would reload the control register with a shifted word that reads as idle. It also holds each enable low on its own for many cycles. A design that opened the window on either enable would drive the line and change the mode.

Loopback is checked across two consecutive windows, including the window in which loopback is switched off. A design that read `rx_word` too late would echo the word of the same frame. A design that used the newly loaded mode too early would send the encoder word instead. Changing `enc_word` in the middle of a window exposes a port that did not latch the word at the first bit. Reset applied while both enables are low must still leave the line undriven and the register at idle.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

    localparam int WORD_W = 8;
    localparam int MODE_W = 3;
    localparam int VW_W   = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_NORMAL   = 3'd0,
        MODE_LCARRIER = 3'd1,
        MODE_LSYNC    = 3'd2,
        MODE_DIGLOOP  = 3'd3,
        MODE_DATALOOP = 3'd4,
        MODE_DLOOP_VW = 3'd5,
        MODE_DRIVE    = 3'd6,
        MODE_IDLE     = 3'd7
    } op_mode_e;

    typedef struct packed {
        op_mode_e          mode;
        logic [VW_W-1:0]   vw;
        logic              clr_act;
        logic              clr_scan;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);
    localparam logic [CTL_W-1:0] CTL_RESET = '1;

    function automatic ctl_word_t unpack_ctl(input logic [CTL_W-1:0] raw);
        return ctl_word_t'(raw);
    endfunction

endpackage

// File: rtl/tdm_win_ctrl.sv
module tdm_win_ctrl
    import tdm_port_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_n,
    input  logic chan_n,
    output logic drive,
    output logic load_now,
    output logic shift_now
);
    localparam int CW = $clog2(W + 1);

    logic          en_low;
    logic [CW-1:0] cnt;

    assign en_low    = ~frame_n & ~chan_n;
    assign load_now  = en_low && (cnt == '0);
    assign shift_now = en_low && (cnt != '0) && (cnt < CW'(W));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            drive <= 1'b0;
        end else if (en_low) begin
            if (cnt < CW'(W)) begin
                cnt   <= cnt + 1'b1;
                drive <= 1'b1;
            end else begin
                drive <= 1'b0;
            end
        end else begin
            cnt   <= '0;
            drive <= 1'b0;
        end
    end

    // consecutive drive cycles, kept only for the window-length check
    logic [CW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)        run_len <= '0;
        else if (drive) run_len <= run_len + 1'b1;
        else            run_len <= '0;
    end

    p_window_len_r2: assert property (@(posedge clk) disable iff (rst)
        drive |-> (run_len < CW'(W)));

    p_drive_needs_en_r1: assert property (@(posedge clk) disable iff (rst)
        drive |-> $past(!frame_n && !chan_n));

endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift
    import tdm_port_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_now,
    input  logic         shift_now,
    input  logic         drive,
    input  logic [W-1:0] word_in,
    output logic         ser_out
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)            sh <= '0;
        else if (load_now)  sh <= word_in;
        else if (shift_now) sh <= {sh[W-2:0], 1'b0};
    end

    assign ser_out = drive & sh[W-1];

endmodule

// File: rtl/tdm_deser.sv
module tdm_deser
    import tdm_port_pkg::*;
#(
    parameter int           W       = WORD_W,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    // bits are taken mid-period, on the falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            sh   <= '0;
            cnt  <= '0;
            word <= RST_VAL;
            done <= 1'b0;
        end else if (sample && (cnt < CW'(W))) begin
            sh  <= {sh[W-2:0], din};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(W - 1)) begin
                word <= {sh[W-2:0], din};
                done <= 1'b1;
            end else begin
                done <= 1'b0;
            end
        end else begin
            if (!sample) cnt <= '0;
            done <= 1'b0;
        end
    end

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !sample |-> $stable(word));

    p_hold_reset_r8: assert property (@(posedge clk)
        rst |=> (word == RST_VAL));

endmodule

// File: rtl/tdm_chan_port.sv
module tdm_chan_port
    import tdm_port_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              chan_n,
    input  logic              rx_ser,
    input  logic              ctl_ser,
    input  logic [W-1:0]      enc_word,
    output logic              tx_ser,
    output logic              tx_oe,
    output logic [W-1:0]      rx_word,
    output logic              rx_new,
    output logic [MODE_W-1:0] mode,
    output logic [VW_W-1:0]   vw_bits,
    output logic              clr_activity,
    output logic              clr_scan,
    output logic              drive_pt
);
    logic             drive;
    logic             load_now;
    logic             shift_now;
    logic [W-1:0]     tx_src;
    logic [CTL_W-1:0] ctl_raw;
    logic             ctl_done;
    ctl_word_t        ctl_q;

    tdm_win_ctrl #(.W(W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .chan_n    (chan_n),
        .drive     (drive),
        .load_now  (load_now),
        .shift_now (shift_now)
    );

    // loopback returns the word held from the previous window
    assign tx_src = (ctl_q.mode == MODE_DIGLOOP) ? rx_word : enc_word;

    tdm_tx_shift #(.W(W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load_now  (load_now),
        .shift_now (shift_now),
        .drive     (drive),
        .word_in   (tx_src),
        .ser_out   (tx_ser)
    );

    tdm_deser #(.W(W), .RST_VAL('0)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .sample (drive),
        .din    (rx_ser),
        .word   (rx_word),
        .done   (rx_new)
    );

    tdm_deser #(.W(CTL_W), .RST_VAL(CTL_RESET)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .sample (drive),
        .din    (ctl_ser),
        .word   (ctl_raw),
        .done   (ctl_done)
    );

    assign ctl_q        = unpack_ctl(ctl_raw);
    assign tx_oe        = drive;
    assign mode         = ctl_q.mode;
    assign vw_bits      = ctl_q.vw;
    assign clr_activity = ctl_q.clr_act;
    assign clr_scan     = ctl_q.clr_scan;
    assign drive_pt     = (ctl_q.mode == MODE_DRIVE);

    p_ctl_one_load_r4: assert property (@(posedge clk) disable iff (rst)
        ctl_done |-> rx_new);

    p_loop_src_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_oe) && mode == MODE_DIGLOOP) |-> (tx_ser == rx_word[W-1]));

    p_enc_src_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_oe) && mode != MODE_DIGLOOP) |-> (tx_ser == $past(enc_word[W-1])));

    p_drive_point_r7: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_DRIVE) |-> !drive_pt);

    p_reset_idle_r8: assert property (@(posedge clk)
        rst |=> (!tx_oe && mode == MODE_IDLE && !drive_pt));

endmodule

// File: tb/tdm_chan_port_tb.sv
module tdm_chan_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_n = 1'b1;
    logic       chan_n = 1'b1;
    logic       rx_ser = 1'b0;
    logic       ctl_ser = 1'b0;
    logic [7:0] enc_word = 8'h00;
    logic       tx_ser, tx_oe, rx_new, clr_activity, clr_scan, drive_pt;
    logic [7:0] rx_word;
    logic [2:0] mode, vw_bits;

    always #10 clk = ~clk;

    tdm_chan_port dut_i (
        .clk(clk), .rst(rst), .frame_n(frame_n), .chan_n(chan_n),
        .rx_ser(rx_ser), .ctl_ser(ctl_ser), .enc_word(enc_word),
        .tx_ser(tx_ser), .tx_oe(tx_oe), .rx_word(rx_word), .rx_new(rx_new),
        .mode(mode), .vw_bits(vw_bits), .clr_activity(clr_activity),
        .clr_scan(clr_scan), .drive_pt(drive_pt)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    int         m_cnt = 0, m_rcnt = 0;
    logic       m_oe = 0, m_bit = 0, m_new = 0;
    logic [7:0] m_word = 0, m_rx = 0, m_ctl = 8'hFF, m_rsh = 0, m_csh = 0;
    logic       p_fn = 1, p_cn = 1, p_rst = 1;
    logic [7:0] p_enc = 0;
    logic       s_oe, s_tx;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_rise();
        if (p_rst) begin
            m_cnt = 0; m_oe = 0;
        end else if (!p_fn && !p_cn) begin
            if (m_cnt < 8) begin
                if (m_cnt == 0) m_word = (m_ctl[7:5] == 3'd3) ? m_rx : p_enc;
                m_bit = m_word[7 - m_cnt];
                m_oe = 1;
                m_cnt++;
            end else m_oe = 0;
        end else begin
            m_cnt = 0; m_oe = 0;
        end
    endtask

    task automatic model_fall();
        if (rst) begin
            m_rcnt = 0; m_ctl = 8'hFF; m_rx = 0; m_new = 0;
        end else if (m_oe && m_rcnt < 8) begin
            m_rsh = {m_rsh[6:0], rx_ser};
            m_csh = {m_csh[6:0], ctl_ser};
            m_rcnt++;
            m_new = (m_rcnt == 8);
            if (m_rcnt == 8) begin m_rx = m_rsh; m_ctl = m_csh; end
        end else begin
            if (!m_oe) m_rcnt = 0;
            m_new = 0;
        end
    endtask

    // one clock: drive at +5, compare at +15
    task automatic cyc(input logic fn, input logic cn, input logic rb, input logic cb);
        frame_n = fn; chan_n = cn; rx_ser = rb; ctl_ser = cb;
        #10;
        model_rise();
        model_fall();
        s_oe = tx_oe; s_tx = tx_ser;
        chk("R1/R2", "tx_oe", tx_oe, m_oe);
        chk("R2", "tx_ser", tx_ser, m_oe ? m_bit : 1'b0);
        chk("R3", "rx_word", rx_word, m_rx);
        chk("R3", "rx_new", rx_new, m_new);
        chk("R5", "control", {mode, vw_bits, clr_activity, clr_scan}, m_ctl);
        chk("R7", "drive_pt", drive_pt, m_ctl[7:5] == 3'd6);
        p_fn = fn; p_cn = cn; p_rst = rst; p_enc = enc_word;
        @(posedge clk); #5;
    endtask

    task automatic window(input logic [7:0] rw, input logic [7:0] cw, input int len,
                          input logic [7:0] e0, input logic [7:0] e1, output logic [7:0] got);
        got = 8'h00;
        for (int k = 0; k <= len; k++) begin
            enc_word = (k >= 3) ? e1 : e0;
            cyc((k < len) ? 1'b0 : 1'b1, (k < len) ? 1'b0 : 1'b1,
                (k >= 1 && k <= 8) ? rw[8 - k] : 1'b1,
                (k >= 1 && k <= 8) ? cw[8 - k] : 1'b1);
            if (k >= 1 && k <= 8 && s_oe) got[8 - k] = s_tx;
        end
        cyc(1, 1, 0, 0);
        cyc(1, 1, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        @(posedge clk); #5;
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0);
        // R8: reset state
        chk("R8", "mode after reset", mode, 7);
        chk("R8", "tx_oe after reset", tx_oe, 0);
        chk("R8", "rx_word after reset", rx_word, 0);
        chk("R8", "clear levels after reset", {clr_activity, clr_scan}, 2'b11);
        rst = 1'b0;
        cyc(1, 1, 0, 0);

        // R9: control input held low selects mode 0
        window(8'hA5, 8'h00, 8, 8'h3C, 8'h3C, got);
        chk("R9", "mode with control low", mode, 0);
        chk("R9", "vw with control low", vw_bits, 0);
        chk("R2", "sent word", got, 8'h3C);
        chk("R3", "received word", rx_word, 8'hA5);

        // R5: field split, mode 3 with vw 101 and activity clear
        window(8'h5A, 8'h76, 8, 8'h11, 8'h11, got);
        chk("R5", "mode field", mode, 3);
        chk("R5", "vw field", vw_bits, 3'b101);
        chk("R5", "clr_activity", clr_activity, 1);
        chk("R5", "clr_scan", clr_scan, 0);
        chk("R2", "sent word before loopback", got, 8'h11);

        // R6: loopback sends previous window's word
        window(8'hC3, 8'h60, 8, 8'hEE, 8'h77, got);
        chk("R6", "loopback word", got, 8'h5A);
        // mode 6 loaded here; this window still starts in mode 3
        window(8'h0F, 8'hC1, 8, 8'hEE, 8'hEE, got);
        chk("R6", "loopback word, last window", got, 8'hC3);
        chk("R7", "drive point in mode 6", drive_pt, 1);

        // R1: one enable alone opens nothing
        for (int i = 0; i < 12; i++) cyc(0, 1, 1, 1);
        cyc(1, 1, 1, 1);
        for (int i = 0; i < 12; i++) cyc(1, 0, 1, 1);
        cyc(1, 1, 0, 0);
        chk("R1", "mode after single enables", mode, 6);
        chk("R1", "rx_word after single enables", rx_word, 8'h0F);

        // R4/R10: long window, junk after 8 bits, encoder word changes mid-window
        window(8'h99, 8'h01, 12, 8'h81, 8'h7E, got);
        chk("R10", "word latched at first bit", got, 8'h81);
        chk("R4", "extra bits ignored, ctl", {mode, vw_bits, clr_activity, clr_scan}, 8'h01);
        chk("R4", "extra bits ignored, rx", rx_word, 8'h99);
        chk("R7", "drive point released", drive_pt, 0);
        chk("R2", "line released after long window", tx_oe, 0);

        // back-to-back windows
        window(8'h24, 8'h00, 8, 8'hB6, 8'hB6, got);
        chk("R2", "second of adjacent windows", got, 8'hB6);

        // R8: reset while enables low
        rst = 1'b1;
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1);
        chk("R8", "tx_oe in reset with enables low", tx_oe, 0);
        rst = 1'b0;
        cyc(1, 1, 0, 0);
        chk("R8", "mode after second reset", mode, 7);
        chk("R8", "rx_word after second reset", rx_word, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule